// File: doc/BRIEF.md
# Prioritized Interrupt Source Vector Controller

This block collects seven level-sensitive interrupt inputs and routes them through six vector registers, one per source group. Inputs 0 and 1 share vector 0, and input k (k = 2..6) owns vector k-1. Every vector holds a destination server number, a priority and a source number. The source number picks which of the six output lines the vector drives. The controller also keeps a status bit per input and a pending flag per vector. The pending flag means "asserted and not masked", and priority 0xFF is the mask value.

Software programs a vector with a single 64-bit write. An accepted write is passed to a downstream presenter as a one-cycle update strobe. The strobe carries the source number, the priority and the server number with its two link-pointer bits removed. A registered read port shows each vector image and the two status words. Presentation to processors and end-of-interrupt handling belong to the presenter, not to this block.

Top module: `irq_vector_ctl`

## Requirements
- R1: After reset, vector i reads server 0, priority 0xFF, source number i and pending 0. All lines, all status bits and `upd_valid` are 0.
- R2: One cycle after an input level changes, its status bit follows the new level. `rd_sel`=6 returns the control word, with input 0 at bit 47 and input 1 at bit 46. `rd_sel`=7 returns the status word, with inputs 2..6 at bits 36 down to 32 (input 2 at bit 36). All other bits of both words read 0.
- R3: `rd_sel`=v (v = 0..5) returns vector v on the cycle after it is selected. The server is in bits 55:40, the priority in 39:32, the source number in 31:29 and pending at bit 24. All other bits read 0.
- R4: One cycle after the inputs change, `line_out[s]` is high exactly when some vector whose source number is s has an active source. Vector 0 is active when input 0 or input 1 is high. Vector k is active when input k+1 is high. The mask does not affect the lines.
- R5: The line driven by vector 0 stays high while either shared input is still high. It lowers only once both inputs are low.
- R6: When the inputs feeding a vector change level, its pending flag becomes (active and priority != 0xFF).
- R7: A vector write replaces server, priority and source number and keeps the pending flag. It clears the flag when the new priority is 0xFF. Pending is not re-evaluated until the vector's inputs next change.
- R8: An accepted write raises `upd_valid` for exactly one cycle, on the following cycle. `upd_server` is write bits 55:42 (the server shifted right by 2), `upd_prio` is bits 39:32 and `upd_src` is bits 31:29.
- R9: A write is rejected if its source number is 6 or 7, or if `cfg_sel` is 6 or 7. A rejected write leaves every vector unchanged and produces no update strobe.
- R10: A vector whose priority is 0xFF never shows pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 7 | Interrupt input levels |
| cfg_we | input | 1 | Vector write enable |
| cfg_sel | input | 3 | Vector index for the write |
| cfg_wdata | input | 64 | Vector write data |
| rd_sel | input | 3 | Read selector: 0..5 vectors, 6 control word, 7 status word |
| rd_data | output | 64 | Registered read data |
| line_out | output | 6 | Interrupt lines, indexed by source number |
| upd_valid | output | 1 | Configuration update strobe |
| upd_src | output | 3 | Source number of the update |
| upd_server | output | 14 | Server number without link bits |
| upd_prio | output | 8 | Priority of the update |

## Verification
Two kinds of internal fault show at the ports one cycle after their cause. A wrong source number moves a line to another index. A stale status bit leaves a shared line up too long. A wrong pending flag appears only in a vector read, two cycles after the input change. It can also hide until the next input change, because pending is re-evaluated only on events, so the bench reads back every vector after every stimulus. A mis-sliced or wrongly accepted write shows on the update strobe on the next cycle.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int SRV_LO   = 40;
  localparam int SRV_W    = 16;
  localparam int PRI_LO   = 32;
  localparam int PRI_W    = 8;
  localparam int SRC_LO   = 29;
  localparam int SRC_W    = 3;
  localparam int PEND_BIT = 24;
  localparam int LINK_W   = 2;
  localparam int CTL_HI   = 47;
  localparam int STAT_TOP = 36;
  localparam logic [PRI_W-1:0] PRI_OFF = '1;

  typedef struct packed {
    logic [SRV_W-1:0] server;
    logic [PRI_W-1:0] prio;
    logic [SRC_W-1:0] src;
    logic             pend;
  } vec_t;

  function automatic logic [63:0] vec_image(vec_t v);
    logic [63:0] w;
    w = '0;
    w[SRV_LO +: SRV_W] = v.server;
    w[PRI_LO +: PRI_W] = v.prio;
    w[SRC_LO +: SRC_W] = v.src;
    w[PEND_BIT]        = v.pend;
    return w;
  endfunction
endpackage

// File: rtl/ivc_vector.sv
module ivc_vector
  import ivc_pkg::*;
#(
  parameter int NUM_VEC   = 6,
  parameter int RESET_SRC = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic             evt,
  input  logic             we,
  input  logic [SRV_W-1:0] wsrv,
  input  logic [PRI_W-1:0] wpri,
  input  logic [SRC_W-1:0] wsrc,
  output vec_t             vec_o,
  output logic [SRC_W-1:0] src_next,
  output logic             accept
);
  localparam logic [SRC_W:0] SRC_LIM = NUM_VEC[SRC_W:0];

  vec_t cur, nxt;
  logic masked;

  assign accept = we && ({1'b0, wsrc} < SRC_LIM);

  always_comb begin
    nxt = cur;
    if (accept) begin
      nxt.server = wsrv;
      nxt.prio   = wpri;
      nxt.src    = wsrc;
    end
    masked   = (nxt.prio == PRI_OFF);
    nxt.pend = evt ? (act && !masked) : (cur.pend && !masked);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur.server <= '0;
      cur.prio   <= PRI_OFF;
      cur.src    <= SRC_W'(RESET_SRC);
      cur.pend   <= 1'b0;
    end else begin
      cur <= nxt;
    end
  end

  assign vec_o    = cur;
  assign src_next = nxt.src;

  assert_mask_pend_R10: assert property (@(posedge clk) disable iff (rst)
    cur.pend |-> (cur.prio != PRI_OFF));

  assert_reject_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (we && !accept) |=> ($stable(cur.server) && $stable(cur.prio) && $stable(cur.src)));

  assert_pend_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!evt && !accept) |=> $stable(cur.pend));
endmodule

// File: rtl/ivc_route.sv
module ivc_route #(
  parameter int NUM_VEC = 6,
  parameter int SRC_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_VEC-1:0]            act,
  input  logic [NUM_VEC-1:0][SRC_W-1:0] src,
  output logic [NUM_VEC-1:0]            line_q
);
  logic [NUM_VEC-1:0] hit;

  always_comb begin
    hit = '0;
    for (int s = 0; s < NUM_VEC; s++) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (act[v] && (src[v] == SRC_W'(s))) hit[s] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= hit;
  end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import ivc_pkg::*;
#(
  parameter int NUM_VEC = 6,
  parameter int DATA_W  = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_VEC:0]          irq_in,
  input  logic                      cfg_we,
  input  logic [2:0]                cfg_sel,
  input  logic [DATA_W-1:0]         cfg_wdata,
  input  logic [2:0]                rd_sel,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_VEC-1:0]        line_out,
  output logic                      upd_valid,
  output logic [SRC_W-1:0]          upd_src,
  output logic [SRV_W-LINK_W-1:0]   upd_server,
  output logic [PRI_W-1:0]          upd_prio
);
  localparam int NUM_IN = NUM_VEC + 1;
  localparam int SEL_W  = 3;

  logic [NUM_IN-1:0]             stat_q;
  logic [NUM_VEC-1:0]            act_d, evt_d, acc;
  logic [NUM_VEC-1:0][SRC_W-1:0] src_d;
  vec_t                          vecs [NUM_VEC];

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= irq_in;
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    if (v == 0) begin : g_shared
      assign act_d[v] = |irq_in[1:0];
      assign evt_d[v] = (irq_in[1:0] != stat_q[1:0]);
    end else begin : g_single
      assign act_d[v] = irq_in[v+1];
      assign evt_d[v] = (irq_in[v+1] != stat_q[v+1]);
    end

    ivc_vector #(.NUM_VEC(NUM_VEC), .RESET_SRC(v)) u_vec (
      .clk      (clk),
      .rst      (rst),
      .act      (act_d[v]),
      .evt      (evt_d[v]),
      .we       (cfg_we && (cfg_sel == SEL_W'(v))),
      .wsrv     (cfg_wdata[SRV_LO +: SRV_W]),
      .wpri     (cfg_wdata[PRI_LO +: PRI_W]),
      .wsrc     (cfg_wdata[SRC_LO +: SRC_W]),
      .vec_o    (vecs[v]),
      .src_next (src_d[v]),
      .accept   (acc[v])
    );
  end

  ivc_route #(.NUM_VEC(NUM_VEC), .SRC_W(SRC_W)) u_route (
    .clk    (clk),
    .rst    (rst),
    .act    (act_d),
    .src    (src_d),
    .line_q (line_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_valid  <= 1'b0;
      upd_src    <= '0;
      upd_server <= '0;
      upd_prio   <= '0;
    end else begin
      upd_valid <= |acc;
      if (|acc) begin
        upd_src    <= cfg_wdata[SRC_LO +: SRC_W];
        upd_server <= cfg_wdata[SRV_LO+LINK_W +: SRV_W-LINK_W];
        upd_prio   <= cfg_wdata[PRI_LO +: PRI_W];
      end
    end
  end

  logic [DATA_W-1:0] ctl_word, stat_word, rd_next;

  always_comb begin
    ctl_word            = '0;
    ctl_word[CTL_HI]    = stat_q[0];
    ctl_word[CTL_HI-1]  = stat_q[1];
    stat_word           = '0;
    for (int k = 2; k < NUM_IN; k++) stat_word[STAT_TOP-(k-2)] = stat_q[k];
    rd_next = '0;
    if (rd_sel == SEL_W'(NUM_VEC))         rd_next = ctl_word;
    else if (rd_sel == SEL_W'(NUM_VEC+1))  rd_next = stat_word;
    else begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (rd_sel == SEL_W'(v)) rd_next = vec_image(vecs[v]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assert_stat_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (stat_q == $past(irq_in)));

  assert_upd_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (|acc) |=> upd_valid);

  assert_upd_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !(|acc) |=> !upd_valid);
endmodule

// File: tb/sim_irq_vector_ctl.sv
module sim_irq_vector_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  irq_in = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic [2:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic [5:0]  line_out;
  logic        upd_valid;
  logic [2:0]  upd_src;
  logic [13:0] upd_server;
  logic [7:0]  upd_prio;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] e_srv [6];
  logic [7:0]  e_pri [6];
  logic [2:0]  e_src [6];
  logic        e_pnd [6];
  logic [6:0]  cur_irq = '0;

  always #5 clk = ~clk;

  irq_vector_ctl u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data), .line_out(line_out),
    .upd_valid(upd_valid), .upd_src(upd_src), .upd_server(upd_server), .upd_prio(upd_prio)
  );

  task automatic chk(input string req, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, a, e);
    end
  endtask

  function automatic logic act_of(input int v, input logic [6:0] p);
    return (v == 0) ? (p[0] | p[1]) : p[v+1];
  endfunction

  function automatic logic [63:0] img(input int v);
    logic [63:0] w = '0;
    w[55:40] = e_srv[v];
    w[39:32] = e_pri[v];
    w[31:29] = e_src[v];
    w[24]    = e_pnd[v];
    return w;
  endfunction

  function automatic logic [5:0] exp_lines();
    logic [5:0] l = '0;
    for (int s = 0; s < 6; s++)
      for (int v = 0; v < 6; v++)
        if (act_of(v, cur_irq) && e_src[v] == 3'(s)) l[s] = 1'b1;
    return l;
  endfunction

  // R4 R5 R6: drive inputs, model pending on events, check lines next cycle
  task automatic drive_irq(input logic [6:0] p);
    for (int v = 0; v < 6; v++) begin
      if (act_of(v, p) != act_of(v, cur_irq) || (v == 0 && p[1:0] != cur_irq[1:0]))
        e_pnd[v] = act_of(v, p) && (e_pri[v] != 8'hFF);
    end
    irq_in  = p;
    cur_irq = p;
    @(negedge clk);
    chk("R4/R5 lines", 64'(line_out), 64'(exp_lines()));
  endtask

  task automatic verify_all();
    logic [63:0] cw, sw;
    for (int v = 0; v < 6; v++) begin
      rd_sel = 3'(v);
      @(negedge clk);
      chk("R3/R6/R7/R10 vector image", rd_data, img(v));
    end
    cw = '0; cw[47] = cur_irq[0]; cw[46] = cur_irq[1];
    sw = '0;
    for (int k = 2; k < 7; k++) sw[36-(k-2)] = cur_irq[k];
    rd_sel = 3'd6; @(negedge clk); chk("R2 control word", rd_data, cw);
    rd_sel = 3'd7; @(negedge clk); chk("R2 status word", rd_data, sw);
  endtask

  task automatic wr(input int sel, input logic [15:0] srv, input logic [7:0] pri, input logic [2:0] src);
    logic [63:0] w = '1;
    bit ok;
    w[55:40] = srv; w[39:32] = pri; w[31:29] = src;
    ok = (sel < 6) && (src < 3'd6);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(ok ? "R8 strobe" : "R9 no strobe", 64'(upd_valid), 64'(ok));
    if (ok) begin
      chk("R8 server", 64'(upd_server), 64'(srv >> 2));
      chk("R8 prio", 64'(upd_prio), 64'(pri));
      chk("R8 src", 64'(upd_src), 64'(src));
      e_srv[sel] = srv; e_pri[sel] = pri; e_src[sel] = src;
      if (pri == 8'hFF) e_pnd[sel] = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 6; v++) begin
      e_srv[v] = '0; e_pri[v] = 8'hFF; e_src[v] = 3'(v); e_pnd[v] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 lines", 64'(line_out), 64'd0);
    chk("R1 strobe", 64'(upd_valid), 64'd0);
    verify_all();

    // masked sources still drive lines, never pend
    for (int i = 0; i < 7; i++) begin
      drive_irq(7'(1 << i));
      verify_all();
      drive_irq(7'd0);
    end

    for (int v = 0; v < 6; v++)
      wr(v, 16'h1234 + 16'(v * 16'h0111), 8'(v * 3 + 1), 3'(v));
    verify_all();

    for (int p = 0; p < 128; p++) begin
      drive_irq(7'(p));
      verify_all();
    end
    drive_irq(7'd0);

    // R7 write keeps pending, mask clears it, unmask does not restore it
    drive_irq(7'h04);
    verify_all();
    wr(1, 16'hBEEF, 8'h40, 3'd1); verify_all();
    wr(1, 16'hBEEF, 8'hFF, 3'd1); verify_all();
    wr(1, 16'hBEEF, 8'h40, 3'd1); verify_all();
    drive_irq(7'd0); drive_irq(7'h04); verify_all();
    drive_irq(7'd0);

    // R9 rejected writes
    wr(2, 16'hFFFF, 8'h00, 3'd6); verify_all();
    wr(2, 16'hFFFF, 8'h00, 3'd7); verify_all();
    wr(6, 16'hFFFF, 8'h00, 3'd1); verify_all();
    wr(7, 16'hFFFF, 8'h00, 3'd2); verify_all();

    // remapped sources, shared vector moved
    wr(2, 16'h0044, 8'h05, 3'd4);
    wr(0, 16'h0ABC, 8'h07, 3'd5);
    wr(5, 16'h0003, 8'hFF, 3'd0);
    for (int p = 0; p < 128; p++) begin
      drive_irq(7'(p));
      if (p % 8 == 0) verify_all();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule